// File: doc/BRIEF.md
# Host Controller Run-Control and Status Registers

This block holds the command and status register pair of a USB 2.0 style host controller, reached over a plain memory-mapped register bus with a single-cycle write strobe and a combinational read path. The command register carries the run/stop control, a self-timed controller reset, the two schedule enables and the frame list size. The status register gathers event bits that software clears by writing ones, next to a read-only halted flag.

Toward an abstracted schedule engine the block drives the run request, the schedule enables, an abort level during a controller reset and a frame-index mask derived from the frame list size. The engine reports back an idle level, so that a stop request turns into a halted indication only after the in-flight work has drained. The frame list size can be changed only when the programmable-frame-list capability input is high.

Register map (byte addresses on `bus_addr`): command at 0x0, status at 0x4. Command bits: run [0], controller reset [1], frame list size [5:4], periodic enable [8], asynchronous enable [9]. Status bits: events [5:0], halted [12]. Other bits read as zero.

Top module: `hc_runctl_regs`

## Requirements
- R1: After the bus reset `rst_n` the command register reads 0, the status register reads only halted (bit 12) set, all outputs to the engine are 0 and `frame_mask` is 0x0FFC.
- R2: A pulse on `evt_in[i]` sets status bit i; writing 1 to status bit i clears it, writing 0 leaves it, and when a pulse and a clearing write hit bit i in the same cycle the bit stays set.
- R3: Writing run (command bit 0) as 1 drives `run_req` high after that clock edge, and halted reads 0 from the following cycle on; `eng_idle` does not set halted while run is 1.
- R4: After run is written 0, halted stays 0 while `eng_idle` is 0 and becomes 1 one cycle after `eng_idle` is seen high with run at 0.
- R5: Writing command bit 1 as 1 starts a controller reset: bit 1 reads 1 and `abort_req` is high for exactly 8 cycles, and from the write edge the command register, status events and engine outputs are at their R1 values with halted 1.
- R6: During a controller reset every register write is ignored; writing 0 or 1 to the reset bit neither ends nor extends it.
- R7: Command bits 8 and 9 drive `sched_per_en` and `sched_async_en` and read back as written.
- R8: With `cap_prog_fl` high the frame list size field [5:4] is writable; codes 00, 01, 10 select 1024, 512, 256 entries and `frame_mask` covers index bits [11:2], [10:2] or [9:2] (0x0FFC, 0x07FC, 0x03FC).
- R9: A write of code 11 to the frame list size field is ignored and the previous code is kept.
- R10: With `cap_prog_fl` low the size field reads 00, writes to it are ignored and `frame_mask` is 0x0FFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_prog_fl | input | 1 | Capability: frame list size is programmable |
| evt_in | input | 6 | Event pulses that set status bits |
| eng_idle | input | 1 | Schedule engine has no work in flight |
| run_req | output | 1 | Engine may execute the schedule |
| sched_per_en | output | 1 | Periodic schedule enabled |
| sched_async_en | output | 1 | Asynchronous schedule enabled |
| frame_mask | output | 14 | Frame index bits used as the list index |
| abort_req | output | 1 | Controller reset in progress, abort work |

## Verification
The hardest situations to reach are the collisions: an event pulse landing in the very cycle software clears the same bit, and register writes (including reset-bit writes of both values) landing in the middle of a controller reset. The bench drives these on purpose by placing the event and the clearing write in one cycle for every event bit, and by issuing a run-plus-reset write a few cycles into the reset window while counting the cycles the reset bit stays high. The drained-halt path is reached by holding `eng_idle` low through a stop request and raising it only later.

// File: rtl/hc_runctl_pkg.sv
// Package: shared field positions and types for the run-control register block.
// Assumes a 32-bit register bus with byte addresses.
package hc_runctl_pkg;

    // Register byte offsets
    localparam logic [3:0] CMD_OFS = 4'h0;
    localparam logic [3:0] STS_OFS = 4'h4;

    // Command register bit positions
    localparam int unsigned CMD_RUN_BIT = 0;
    localparam int unsigned CMD_RST_BIT = 1;
    localparam int unsigned CMD_FLS_LSB = 4;
    localparam int unsigned CMD_PER_BIT = 8;
    localparam int unsigned CMD_ASY_BIT = 9;

    // Status register halted flag position
    localparam int unsigned STS_HALT_BIT = 12;

    // Frame list size codes
    typedef enum logic [1:0] {
        FLS_1024 = 2'b00,
        FLS_512  = 2'b01,
        FLS_256  = 2'b10,
        FLS_RSVD = 2'b11
    } fls_e;

    // Decoded command fields
    typedef struct packed {
        logic run;
        logic per_en;
        logic async_en;
        fls_e fls;
    } cmd_t;

    localparam cmd_t CMD_INIT = '{run: 1'b0, per_en: 1'b0, async_en: 1'b0, fls: FLS_1024};

endpackage

// File: rtl/hc_reset_seq.sv
// Module: self-timed controller reset sequencer.
// A start pulse raises busy for exactly RST_CYC cycles; further starts while
// busy are not expected (the top gates them) and nothing can end it early.
module hc_reset_seq #(
    parameter int unsigned RST_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;

    logic [CNT_W-1:0] cnt_q;

    // Load the down-counter on start, drop busy when it has run out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(RST_CYC - 1);
        end
    end

endmodule

// File: rtl/hc_cmd_reg.sv
// Module: command fields (run, schedule enables, frame list size).
// Assumes wr_en is already qualified by address and by the absence of a reset.
// The size field is written only when cap is high and the code is not reserved.
module hc_cmd_reg
    import hc_runctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_clr,
    input  logic       wr_en,
    input  logic       w_run,
    input  logic       w_per,
    input  logic       w_async,
    input  logic [1:0] w_fls,
    input  logic       cap,
    output cmd_t       cmd
);
    logic fls_ok;

    // Size writes need the capability and a non-reserved code
    always_comb fls_ok = cap && (fls_e'(w_fls) != FLS_RSVD);

    // Hold the command fields; soft reset returns them to their initial values
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            cmd <= CMD_INIT;
        end else if (wr_en) begin
            cmd.run      <= w_run;
            cmd.per_en   <= w_per;
            cmd.async_en <= w_async;
            if (fls_ok) begin
                cmd.fls <= fls_e'(w_fls);
            end
        end
    end

endmodule

// File: rtl/hc_halt_track.sv
// Module: halted flag tracker.
// Halted is 1 out of reset, clears one cycle after run is 1, and sets one
// cycle after the engine reports idle while run is 0.
module hc_halt_track (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic run,
    input  logic eng_idle,
    output logic halted
);
    // Follow run and the engine's drain status
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            halted <= 1'b1;
        end else if (run) begin
            halted <= 1'b0;
        end else if (eng_idle) begin
            halted <= 1'b1;
        end
    end

endmodule

// File: rtl/hc_status_reg.sv
// Module: write-one-to-clear event bits.
// A set pulse wins over a clear of the same bit in the same cycle.
module hc_status_reg #(
    parameter int unsigned NEVT = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_clr,
    input  logic [NEVT-1:0] evt,
    input  logic            clr_en,
    input  logic [NEVT-1:0] clr_mask,
    output logic [NEVT-1:0] sts
);
    logic [NEVT-1:0] clr_bits;

    // Bits actually cleared this cycle
    always_comb clr_bits = clr_en ? clr_mask : '0;

    // Per-bit set/clear with set priority
    for (genvar g = 0; g < NEVT; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr) begin
                sts[g] <= 1'b0;
            end else if (evt[g]) begin
                sts[g] <= 1'b1;
            end else if (clr_bits[g]) begin
                sts[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hc_frame_mask.sv
// Module: frame-index mask from the frame list size.
// Index bits [MAX_LOG2+1-size : 2] are set; a reserved code maps as 1024.
module hc_frame_mask
    import hc_runctl_pkg::*;
#(
    parameter int unsigned IDX_W    = 14,
    parameter int unsigned MAX_LOG2 = 10
) (
    input  fls_e             fls,
    output logic [IDX_W-1:0] mask
);
    localparam int TOP_MAX = int'(MAX_LOG2) + 1;

    int top_i;

    // Highest index bit in use for the selected size
    always_comb begin
        case (fls)
            FLS_512: top_i = TOP_MAX - 1;
            FLS_256: top_i = TOP_MAX - 2;
            default: top_i = TOP_MAX;
        endcase
    end

    // One mask bit per index position
    for (genvar g = 0; g < IDX_W; g++) begin : g_mask
        assign mask[g] = (g >= 2) && (g <= top_i);
    end

endmodule

// File: rtl/hc_runctl_regs.sv
// Module: top of the host controller command/status register block.
// Decodes bus writes, runs the reset sequencer, and exposes engine controls.
// Assumes one write strobe per access and reads taken combinationally.
module hc_runctl_regs
    import hc_runctl_pkg::*;
#(
    parameter int unsigned NEVT     = 6,
    parameter int unsigned RST_CYC  = 8,
    parameter int unsigned IDX_W    = 14,
    parameter int unsigned MAX_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             cap_prog_fl,
    input  logic [NEVT-1:0]  evt_in,
    input  logic             eng_idle,
    output logic             run_req,
    output logic             sched_per_en,
    output logic             sched_async_en,
    output logic [IDX_W-1:0] frame_mask,
    output logic             abort_req
);
    logic            busy;
    logic            cmd_hit;
    logic            sts_hit;
    logic            rst_start;
    logic            cmd_wr;
    logic            soft_clr;
    logic            halted;
    logic [NEVT-1:0] sts_evt;
    cmd_t            cmd;
    fls_e            fls_eff;
    logic            wdata_unused;

    // Address and write qualification
    always_comb begin
        cmd_hit   = bus_wr && (bus_addr == CMD_OFS) && !busy;
        sts_hit   = bus_wr && (bus_addr == STS_OFS) && !busy;
        rst_start = cmd_hit && bus_wdata[CMD_RST_BIT];
        cmd_wr    = cmd_hit && !bus_wdata[CMD_RST_BIT];
        soft_clr  = busy || rst_start;
    end

    // Fold write-data bits no register uses
    assign wdata_unused = ^bus_wdata;

    hc_reset_seq #(.RST_CYC(RST_CYC)) i_rst_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_start),
        .busy  (busy)
    );

    hc_cmd_reg i_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .wr_en    (cmd_wr),
        .w_run    (bus_wdata[CMD_RUN_BIT]),
        .w_per    (bus_wdata[CMD_PER_BIT]),
        .w_async  (bus_wdata[CMD_ASY_BIT]),
        .w_fls    (bus_wdata[CMD_FLS_LSB+1:CMD_FLS_LSB]),
        .cap      (cap_prog_fl),
        .cmd      (cmd)
    );

    hc_halt_track i_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .run      (cmd.run),
        .eng_idle (eng_idle),
        .halted   (halted)
    );

    hc_status_reg #(.NEVT(NEVT)) i_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .evt      (evt_in),
        .clr_en   (sts_hit),
        .clr_mask (bus_wdata[NEVT-1:0]),
        .sts      (sts_evt)
    );

    // Size seen by software and the engine: forced to 1024 without the capability
    always_comb fls_eff = cap_prog_fl ? cmd.fls : FLS_1024;

    hc_frame_mask #(.IDX_W(IDX_W), .MAX_LOG2(MAX_LOG2)) i_mask (
        .fls  (fls_eff),
        .mask (frame_mask)
    );

    // Engine-side outputs
    always_comb begin
        run_req        = cmd.run;
        sched_per_en   = cmd.per_en;
        sched_async_en = cmd.async_en;
        abort_req      = busy;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            CMD_OFS: begin
                bus_rdata[CMD_RUN_BIT]                 = cmd.run;
                bus_rdata[CMD_RST_BIT]                 = busy;
                bus_rdata[CMD_FLS_LSB+1:CMD_FLS_LSB]   = fls_eff;
                bus_rdata[CMD_PER_BIT]                 = cmd.per_en;
                bus_rdata[CMD_ASY_BIT]                 = cmd.async_en;
            end
            STS_OFS: begin
                bus_rdata[NEVT-1:0]   = sts_evt;
                bus_rdata[STS_HALT_BIT] = halted;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hc_runctl_chk.sv
// Module: assertion checker bound to the register block top.
// Counts reset cycles itself so no property needs a parameter-sized delay.
module hc_runctl_chk #(
    parameter int unsigned RST_CYC  = 8,
    parameter int unsigned IDX_W    = 14,
    parameter int unsigned MAX_LOG2 = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_req,
    input logic             sched_per_en,
    input logic             sched_async_en,
    input logic             abort_req,
    input logic             eng_idle,
    input logic             cap_prog_fl,
    input logic             halted,
    input logic [IDX_W-1:0] frame_mask
);
    function automatic logic [IDX_W-1:0] mask_for(int top);
        logic [IDX_W-1:0] m;
        for (int i = 0; i < int'(IDX_W); i++) m[i] = (i >= 2) && (i <= top);
        return m;
    endfunction

    localparam logic [IDX_W-1:0] M_FULL = mask_for(int'(MAX_LOG2) + 1);
    localparam logic [IDX_W-1:0] M_HALF = mask_for(int'(MAX_LOG2));
    localparam logic [IDX_W-1:0] M_QRT  = mask_for(int'(MAX_LOG2) - 1);

    logic [15:0] busy_cnt;

    // Number of consecutive cycles abort has been high before this one
    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= '0;
        else if (abort_req) busy_cnt <= busy_cnt + 1'b1;
        else busy_cnt <= '0;
    end

    AST_RUN_CLEARS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && !abort_req) |=> (!halted || abort_req)); // R3

    AST_HALT_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> (abort_req || ($past(eng_idle) && !$past(run_req)))); // R4

    AST_RESET_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(abort_req) |-> (busy_cnt == 16'(RST_CYC))); // R5

    AST_RESET_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (busy_cnt < 16'(RST_CYC))); // R6

    AST_RESET_INIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (!run_req && !sched_per_en && !sched_async_en && halted && frame_mask == M_FULL)); // R5

    AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_mask == M_FULL) || (frame_mask == M_HALF) || (frame_mask == M_QRT)); // R8

    AST_NOCAP_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_prog_fl |-> (frame_mask == M_FULL)); // R10

endmodule

bind hc_runctl_regs hc_runctl_chk #(
    .RST_CYC  (RST_CYC),
    .IDX_W    (IDX_W),
    .MAX_LOG2 (MAX_LOG2)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_req        (run_req),
    .sched_per_en   (sched_per_en),
    .sched_async_en (sched_async_en),
    .abort_req      (abort_req),
    .eng_idle       (eng_idle),
    .cap_prog_fl    (cap_prog_fl),
    .halted         (halted),
    .frame_mask     (frame_mask)
);

// File: tb/test_hc_runctl_regs.sv
// Bench: sweeps of command fields, event bits and the reset window.
module test_hc_runctl_regs;
    localparam logic [3:0] A_CMD = 4'h0;
    localparam logic [3:0] A_STS = 4'h4;
    localparam logic [31:0] HALT = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_prog_fl = 1'b1;
    logic [5:0]  evt_in = '0;
    logic        eng_idle = 1'b1;
    logic        run_req, sched_per_en, sched_async_en, abort_req;
    logic [13:0] frame_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hc_runctl_regs i_hc_runctl_regs (.*);

    function automatic logic [13:0] exp_mask(int s);
        return 14'(((1 << (12 - s)) - 1) & ~3);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int exp_fls;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CMD, d); chk("R1 cmd", d, 32'h0);
        rd(A_STS, d); chk("R1 sts", d, HALT);
        chk("R1 mask", 32'(frame_mask), 32'h0FFC);
        chk("R1 outs", {run_req, sched_per_en, sched_async_en, abort_req}, 0);

        // R7 sweep of schedule enables
        for (int k = 0; k < 4; k++) begin
            wr(A_CMD, 32'(k) << 8);
            chk("R7 per", sched_per_en, k & 1);
            chk("R7 async", sched_async_en, (k >> 1) & 1);
            rd(A_CMD, d); chk("R7 readback", d, 32'(k) << 8);
        end

        // R8 / R9 size sweep, ascending then descending codes
        exp_fls = 0;
        for (int p = 0; p < 2; p++) begin
            for (int j = 0; j < 4; j++) begin
                int c = (p == 0) ? j : 3 - j;
                wr(A_CMD, 32'(c) << 4);
                if (c != 3) exp_fls = c;
                rd(A_CMD, d);
                chk((c == 3) ? "R9 size kept" : "R8 size", d, 32'(exp_fls) << 4);
                chk((c == 3) ? "R9 mask kept" : "R8 mask", 32'(frame_mask), 32'(exp_mask(exp_fls)));
            end
        end

        // R10 capability low
        wr(A_CMD, 32'h20);
        cap_prog_fl = 1'b0;
        #1;
        rd(A_CMD, d); chk("R10 reads 00", d, 32'h0);
        chk("R10 mask", 32'(frame_mask), 32'h0FFC);
        wr(A_CMD, 32'h10);
        rd(A_CMD, d); chk("R10 write ignored", d, 32'h0);
        chk("R10 mask after write", 32'(frame_mask), 32'h0FFC);
        cap_prog_fl = 1'b1;
        wr(A_CMD, 32'h0);

        // R2 event bits sweep
        for (int i = 0; i < 6; i++) begin
            evt_in = 6'(1 << i);
            @(negedge clk);
            evt_in = '0;
            rd(A_STS, d); chk("R2 set", d, HALT | (32'h1 << i));
            wr(A_STS, 32'h0);
            rd(A_STS, d); chk("R2 zero write keeps", d, HALT | (32'h1 << i));
            wr(A_STS, ~(32'h1 << i));
            rd(A_STS, d); chk("R2 other ones keep", d, HALT | (32'h1 << i));
            wr(A_STS, 32'h1 << i);
            rd(A_STS, d); chk("R2 clear", d, HALT);
            evt_in = 6'(1 << i);
            wr(A_STS, 32'h1 << i);
            evt_in = '0;
            rd(A_STS, d); chk("R2 set wins", d, HALT | (32'h1 << i));
            wr(A_STS, 32'hFFFF_FFFF);
            rd(A_STS, d); chk("R2 halted read-only", d, HALT);
        end

        // R3 run
        wr(A_CMD, 32'h1);
        chk("R3 run_req", run_req, 1);
        rd(A_STS, d); chk("R3 halted same cycle", d, HALT);
        @(negedge clk);
        rd(A_STS, d); chk("R3 halted cleared", d, 32'h0);
        repeat (3) @(negedge clk);
        rd(A_STS, d); chk("R3 idle ignored while run", d, 32'h0);

        // R4 stop and drain
        eng_idle = 1'b0;
        wr(A_CMD, 32'h0);
        chk("R4 run_req off", run_req, 0);
        repeat (4) @(negedge clk);
        rd(A_STS, d); chk("R4 not halted while busy", d, 32'h0);
        eng_idle = 1'b1;
        #1;
        rd(A_STS, d); chk("R4 no halt before edge", d, 32'h0);
        @(negedge clk);
        rd(A_STS, d); chk("R4 halted after idle", d, HALT);

        // R5 / R6 controller reset window
        cap_prog_fl = 1'b1;
        eng_idle = 1'b0;
        wr(A_CMD, 32'h311);
        evt_in = 6'h05;
        @(negedge clk);
        evt_in = '0;
        wr(A_CMD, 32'h2);
        rd(A_CMD, d); chk("R5 reset bit reads 1", d, 32'h2);
        rd(A_STS, d); chk("R5 status cleared", d, HALT);
        chk("R5 outputs init", {run_req, sched_per_en, sched_async_en}, 0);
        chk("R5 mask init", 32'(frame_mask), 32'h0FFC);
        n = 0;
        for (int k = 0; k < 12; k++) begin
            if (abort_req) n++;
            if (k == 3) begin
                bus_wr = 1'b1; bus_addr = A_CMD; bus_wdata = 32'h303;
            end
            if (k == 5) begin
                bus_wr = 1'b1; bus_addr = A_CMD; bus_wdata = 32'h0;
            end
            if (k == 6) begin
                bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = 32'hFFFF;
            end
            @(negedge clk);
            bus_wr = 1'b0; bus_wdata = '0;
        end
        chk("R5 reset length", 32'(n), 32'd8);
        chk("R6 write during reset ignored", {run_req, sched_per_en, sched_async_en}, 0);
        rd(A_CMD, d); chk("R6 cmd after reset", d, 32'h0);
        rd(A_STS, d); chk("R6 sts after reset", d, HALT);

        // Register works again after the window
        wr(A_CMD, 32'h201);
        chk("R7 after reset", {run_req, sched_async_en}, 2'b11);
        wr(A_CMD, 32'h0);

        finish_run();
    end

endmodule